// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

A synthesizable behavioural model of a synchronous static RAM in which reads and writes can follow each other on every clock with no idle cycle between them. Commands, addresses and byte enables are captured on the rising clock edge. Write data arrives late, a fixed number of cycles after its address. Because of this, a write slot on the data bus always lines up with where a read would have returned its data, and the bus never needs a turnaround gap.

A static mode input chooses the read timing. In flow-through mode, read data comes straight from the array in the cycle after the command. In pipelined mode, read data passes through one more output register. A second static input chooses linear or interleaved order for the 4-beat burst, which is driven by an advance input. Words are made of 9-bit bytes, and each byte has its own write enable. Three chip enables gate selection. An asynchronous output enable blanks the read data, and an asynchronous sleep input blocks new commands. If a pipelined read hits an address whose write data has not landed yet, the read returns the incoming data, merged byte by byte with the stored word.

Top module: `nbt_sram`

## Requirements
- R1: A new access starts only when en0_n=0, en1=1, en2_n=0, adv=0 and sleep=0. Any other enable combination with adv=0 is a deselect: it starts nothing and ends any burst. adv=1 with no burst in progress also does nothing.
- R2: With flow_mode=1, the data of a read sampled at edge N is driven on rdata with rdata_en=1 from just after edge N until edge N+1.
- R3: With flow_mode=0, the same read data appears one clock later: after edge N+1, held until edge N+2.
- R4: The data of a write sampled at edge N is taken from wdata at edge N+1 when flow_mode=1, and at edge N+2 when flow_mode=0. Reads and writes may alternate on consecutive cycles.
- R5: bw_n[i]=0 writes bits [BYTE_W*i+BYTE_W-1 : BYTE_W*i] of the word. bw_n[i]=1 leaves those bits unchanged.
- R6: With adv=1 after an access, the burst continues in the same direction. Beat k (k=0..3, wrapping) uses the low two address bits (a+k) mod 4 when burst_ilv=0, or a XOR k when burst_ilv=1. The upper address bits stay unchanged.
- R7: With flow_mode=0, a read sampled one cycle after a write to the same address returns the write's data in the enabled bytes and the stored data in the other bytes.
- R8: oe_n=1 forces rdata_en=0 and rdata=0 at once. This does not disturb reads in progress.
- R9: While sleep=1, the sampled command is ignored: no read data is produced and no array location is written.
- R10: During and after reset, rdata_en=0 and rdata=0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | Static: 1 flow-through, 0 pipelined |
| burst_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sleep | input | 1 | Power-down request; new commands ignored |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue current burst instead of loading an address |
| we_n | input | 1 | 0 write, 1 read (on address load) |
| bw_n | input | BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | BYTES*BYTE_W | Read data, zero when not driven |
| rdata_en | output | 1 | High when rdata carries valid read data |

## Verification
In pipelined mode, two things can fall on the same clock edge: the late write of one command lands in the array, and the output register captures a read of that same address issued one cycle later. The bench provokes this with a write immediately followed by a read of the same word. It does this once with all bytes enabled and once with only the low byte enabled. The captured word must show the new bytes and the stored bytes exactly as R7 prescribes. A second overlap is also covered: the last beats of a write burst land while a read burst of the same four words is starting. That read is judged beat by beat in wrapped order.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_CONT = 2'd2
   } cmd_e;

   // low two address bits of beat k of a burst starting at 'start'
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] k,
                                           input logic       ilv);
      logic [1:0] r;
      if (ilv) r = start ^ k;
      else     r = start + k;
      return r;
   endfunction

endpackage

// File: rtl/nbt_cmd_stage.sv
module nbt_cmd_stage
   import nbt_sram_pkg::*;
#(
   parameter int AW = 8,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep,
   input  logic          en0_n,
   input  logic          en1,
   input  logic          en2_n,
   input  logic          adv,
   input  logic          we_n,
   input  logic          burst_ilv,
   input  logic [NB-1:0] bw_n,
   input  logic [AW-1:0] addr,
   output logic          s1_valid,
   output logic          s1_write,
   output logic [AW-1:0] s1_addr,
   output logic [NB-1:0] s1_bw_n
);

   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic          wr_q;
   logic          active_q;
   logic          selected;
   cmd_e          cmd;
   logic [1:0]    next_cnt;
   logic [AW-1:0] cont_addr;

   always_comb begin
      selected  = !en0_n && en1 && !en2_n;
      next_cnt  = cnt_q + 2'd1;
      cont_addr = {base_q[AW-1:2], beat_low(base_q[1:0], next_cnt, burst_ilv)};
      if (sleep)        cmd = CMD_IDLE;
      else if (!adv)    cmd = selected ? CMD_LOAD : CMD_IDLE;
      else              cmd = active_q ? CMD_CONT : CMD_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         wr_q     <= 1'b0;
         active_q <= 1'b0;
         s1_valid <= 1'b0;
         s1_write <= 1'b0;
         s1_addr  <= '0;
         s1_bw_n  <= '1;
      end else begin
         s1_bw_n <= bw_n;
         unique case (cmd)
            CMD_LOAD: begin
               base_q   <= addr;
               cnt_q    <= 2'd0;
               wr_q     <= !we_n;
               active_q <= 1'b1;
               s1_valid <= 1'b1;
               s1_write <= !we_n;
               s1_addr  <= addr;
            end
            CMD_CONT: begin
               cnt_q    <= next_cnt;
               s1_valid <= 1'b1;
               s1_write <= wr_q;
               s1_addr  <= cont_addr;
            end
            default: begin
               active_q <= 1'b0;
               s1_valid <= 1'b0;
               s1_write <= 1'b0;
            end
         endcase
      end
   end

   // R1: a deselect with no advance starts no access
   p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && (en0_n || !en1 || en2_n)) |=> !s1_valid);

   // R9: sleep blocks every command
   p_sleep_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !s1_valid);

   // R6: a continued beat keeps direction and upper address bits
   p_burst_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && adv && active_q) |=>
         (s1_valid && $stable(s1_write) && s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

endmodule

// File: rtl/nbt_write_pipe.sv
module nbt_write_pipe #(
   parameter int AW = 8,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flow_mode,
   input  logic          s1_valid,
   input  logic          s1_write,
   input  logic [AW-1:0] s1_addr,
   input  logic [NB-1:0] s1_bw_n,
   output logic          commit_en,
   output logic [AW-1:0] commit_addr,
   output logic [NB-1:0] commit_bw_n,
   output logic          fwd_hit
);

   logic          s2_valid;
   logic          s2_write;
   logic [AW-1:0] s2_addr;
   logic [NB-1:0] s2_bw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_write <= 1'b0;
         s2_addr  <= '0;
         s2_bw_n  <= '1;
      end else begin
         s2_valid <= s1_valid;
         s2_write <= s1_write;
         s2_addr  <= s1_addr;
         s2_bw_n  <= s1_bw_n;
      end
   end

   always_comb begin
      if (flow_mode) begin
         commit_en   = s1_valid && s1_write;
         commit_addr = s1_addr;
         commit_bw_n = s1_bw_n;
         fwd_hit     = 1'b0;
      end else begin
         commit_en   = s2_valid && s2_write;
         commit_addr = s2_addr;
         commit_bw_n = s2_bw_n;
         fwd_hit     = s2_valid && s2_write && s1_valid && !s1_write
                       && (s2_addr == s1_addr);
      end
   end

   // R4: pipelined write lands two edges after its address
   p_late_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && $past(s1_valid && s1_write)) |->
         (commit_en && commit_addr == $past(s1_addr)));

   // R7: forwarding only while the matching write is landing
   p_fwd_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_hit |-> (commit_en && commit_addr == s1_addr && !s1_write));

endmodule

// File: rtl/nbt_storage.sv
module nbt_storage #(
   parameter  int AW = 8,
   parameter  int NB = 2,
   parameter  int BW = 9,
   localparam int DW = NB * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [NB-1:0] wbw_n,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   input  logic          fwd_hit,
   output logic [DW-1:0] rword
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] arr_word;

   always_ff @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         if (we && !wbw_n[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
   end

   assign arr_word = mem[raddr];

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rword[b*BW +: BW] = (fwd_hit && !wbw_n[b]) ? wdata[b*BW +: BW]
                                                         : arr_word[b*BW +: BW];

      // R5: a masked byte keeps its old value
      p_keep_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wbw_n[b]) |=>
            (mem[$past(waddr)][b*BW +: BW] === $past(mem[waddr][b*BW +: BW])));

      // R5: an enabled byte takes the late data
      p_take_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !wbw_n[b]) |=>
            (mem[$past(waddr)][b*BW +: BW] === $past(wdata[b*BW +: BW])));
   end

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 2,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow_mode,
   input  logic                    burst_ilv,
   input  logic                    sleep,
   input  logic                    en0_n,
   input  logic                    en1,
   input  logic                    en2_n,
   input  logic                    adv,
   input  logic                    we_n,
   input  logic [BYTES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   input  logic                    oe_n,
   output logic [BYTES*BYTE_W-1:0] rdata,
   output logic                    rdata_en
);

   localparam int DW = BYTES * BYTE_W;

   if (ADDR_W < 3 || ADDR_W > 20) begin : g_bad_addr
      $error("nbt_sram: ADDR_W must lie in 3..20");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_word
      $error("nbt_sram: BYTES and BYTE_W must be positive");
   end

   logic              s1_valid, s1_write;
   logic [ADDR_W-1:0] s1_addr;
   logic [BYTES-1:0]  s1_bw_n;
   logic              commit_en, fwd_hit;
   logic [ADDR_W-1:0] commit_addr;
   logic [BYTES-1:0]  commit_bw_n;
   logic [DW-1:0]     rd_word;
   logic [DW-1:0]     out_q;
   logic              outv_q;
   logic              now_valid;
   logic              sel_valid;
   logic [DW-1:0]     sel_word;

   nbt_cmd_stage #(.AW(ADDR_W), .NB(BYTES)) u_cmd (
      .clk(clk), .rst_n(rst_n), .sleep(sleep),
      .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
      .adv(adv), .we_n(we_n), .burst_ilv(burst_ilv),
      .bw_n(bw_n), .addr(addr),
      .s1_valid(s1_valid), .s1_write(s1_write),
      .s1_addr(s1_addr), .s1_bw_n(s1_bw_n)
   );

   nbt_write_pipe #(.AW(ADDR_W), .NB(BYTES)) u_wpipe (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
      .s1_valid(s1_valid), .s1_write(s1_write),
      .s1_addr(s1_addr), .s1_bw_n(s1_bw_n),
      .commit_en(commit_en), .commit_addr(commit_addr),
      .commit_bw_n(commit_bw_n), .fwd_hit(fwd_hit)
   );

   nbt_storage #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(commit_en), .waddr(commit_addr),
      .wbw_n(commit_bw_n), .wdata(wdata), .raddr(s1_addr),
      .fwd_hit(fwd_hit), .rword(rd_word)
   );

   assign now_valid = s1_valid && !s1_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outv_q <= 1'b0;
         out_q  <= '0;
      end else begin
         outv_q <= now_valid;
         if (now_valid) out_q <= rd_word;
      end
   end

   always_comb begin
      sel_valid = flow_mode ? now_valid : outv_q;
      sel_word  = flow_mode ? rd_word   : out_q;
      rdata_en  = sel_valid && !oe_n;
      rdata     = rdata_en ? sel_word : '0;
   end

   // R2: flow-through read visible in the cycle after its command
   p_flow_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && s1_valid && !s1_write && !oe_n) |-> rdata_en);

   // R3: pipelined read one cycle later, carrying the word read then
   p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && !oe_n && $past(s1_valid && !s1_write)) |->
         (rdata_en && rdata == $past(rd_word)));

   // R8: output enable high blanks the data
   p_oe_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rdata_en && rdata == '0));

endmodule

// File: tb/test_nbt_sram.sv
`timescale 1ns/100ps
module test_nbt_sram;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flow_mode = 1'b0, burst_ilv = 1'b0, sleep = 1'b0;
   logic        en0_n = 1'b1, en1 = 1'b1, en2_n = 1'b0, adv = 1'b0, we_n = 1'b1;
   logic [1:0]  bw_n = 2'b11;
   logic [7:0]  addr = '0;
   logic [17:0] wdata = '0;
   logic        oe_n = 1'b0;
   logic [17:0] rdata;
   logic        rdata_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nbt_sram i_nbt_sram (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
      .sleep(sleep), .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .adv(adv),
      .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
      .rdata(rdata), .rdata_en(rdata_en)
   );

   // op: 0 deselect, 1 read, 2 write, 3 advance, 4 read with en1 low,
   //     5 read with en2_n high, 6 read under sleep, 7 write under sleep
   typedef struct packed {
      logic [2:0]  op;
      logic [7:0]  a;
      logic [1:0]  bw;
      logic [17:0] wd;
      logic        oe;
      logic        en;
      logic [17:0] d;
      logic [3:0]  rq;
   } row_t;

   localparam int NROWS = 35;
   // pipelined mode, linear bursts; expectation is what the ports show after the row's edge
   localparam row_t TBL [NROWS] = '{
      '{3'd2, 8'h10, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd4},  // R4 write
      '{3'd2, 8'h11, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd4},
      '{3'd1, 8'h10, 2'b00, 18'h0A5A5, 1'b0, 1'b0, 18'h00000, 4'd4},  // data of row 0
      '{3'd1, 8'h11, 2'b00, 18'h12345, 1'b0, 1'b1, 18'h0A5A5, 4'd3},  // R3 latency
      '{3'd2, 8'h20, 2'b00, 18'h00000, 1'b0, 1'b1, 18'h12345, 4'd4},  // R4 read->write
      '{3'd1, 8'h20, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd3},
      '{3'd1, 8'h20, 2'b00, 18'h3C3C3, 1'b0, 1'b1, 18'h3C3C3, 4'd7},  // R7 full forward
      '{3'd2, 8'h20, 2'b10, 18'h00000, 1'b0, 1'b1, 18'h3C3C3, 4'd3},
      '{3'd1, 8'h20, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd3},
      '{3'd0, 8'h00, 2'b11, 18'h3FFFF, 1'b0, 1'b1, 18'h3C3FF, 4'd5},  // R5 byte merge via forward
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},
      '{3'd2, 8'h31, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd6},  // R6 write burst
      '{3'd3, 8'h00, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd6},
      '{3'd3, 8'h00, 2'b00, 18'h00001, 1'b0, 1'b0, 18'h00000, 4'd6},
      '{3'd3, 8'h00, 2'b00, 18'h00002, 1'b0, 1'b0, 18'h00000, 4'd6},
      '{3'd1, 8'h33, 2'b00, 18'h00003, 1'b0, 1'b0, 18'h00000, 4'd6},
      '{3'd3, 8'h00, 2'b00, 18'h00004, 1'b0, 1'b1, 18'h00003, 4'd6},
      '{3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00004, 4'd6},
      '{3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00001, 4'd6},
      '{3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00002, 4'd6},
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00003, 4'd6},  // R6 wrap
      '{3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},  // R1 stray advance
      '{3'd1, 8'h10, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd8},
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b1, 1'b0, 18'h00000, 4'd8},  // R8 blanked
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd8},
      '{3'd4, 8'h10, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},
      '{3'd5, 8'h10, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},
      '{3'd6, 8'h10, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd1},  // R1 en2_n high
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd9},  // R9 sleep read
      '{3'd7, 8'h10, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd9},
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd9},
      '{3'd0, 8'h00, 2'b11, 18'h00155, 1'b0, 1'b0, 18'h00000, 4'd9},
      '{3'd1, 8'h10, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h00000, 4'd9},
      '{3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h0A5A5, 4'd9}   // R9 word untouched
   };

   task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [1:0] bw,
                        input logic [17:0] wd, input logic oe);
      en0_n = (op == 3'd0);
      en1   = (op != 3'd4);
      en2_n = (op == 3'd5);
      adv   = (op == 3'd3);
      we_n  = !(op == 3'd2 || op == 3'd7);
      sleep = (op == 3'd6 || op == 3'd7);
      addr  = a;
      bw_n  = bw;
      wdata = wd;
      oe_n  = oe;
   endtask

   task automatic check(input logic en, input logic [17:0] d, input int rq, input int tag);
      checks++;
      if (rdata_en !== en || rdata !== (en ? d : 18'h0)) begin
         failures++;
         $display("FAIL R%0d step %0d: rdata_en=%0b rdata=%h expected en=%0b data=%h",
                  rq, tag, rdata_en, rdata, en, en ? d : 18'h0);
      end
   endtask

   task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [1:0] bw,
                       input logic [17:0] wd, input logic oe, input logic en,
                       input logic [17:0] d, input int rq, input int tag);
      drive(op, a, bw, wd, oe);
      @(posedge clk);
      @(negedge clk);
      check(en, d, rq, tag);
   endtask

   task automatic do_reset(input logic fm, input logic ilv);
      rst_n = 1'b0;
      flow_mode = fm;
      burst_ilv = ilv;
      drive(3'd0, 8'h00, 2'b11, 18'h0, 1'b0);
      repeat (3) @(negedge clk);
      check(1'b0, 18'h0, 10, 900);   // R10 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, 18'h0, 10, 901);   // R10 after release
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin : main
      do_reset(1'b0, 1'b0);
      for (int i = 0; i < NROWS; i++) begin
         step(TBL[i].op, TBL[i].a, TBL[i].bw, TBL[i].wd, TBL[i].oe,
              TBL[i].en, TBL[i].d, int'(TBL[i].rq), i);
      end

      // flow-through mode with interleaved bursts
      do_reset(1'b1, 1'b1);
      step(3'd2, 8'h40, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h0,     4, 100); // R4
      step(3'd1, 8'h40, 2'b00, 18'h2D2D2, 1'b0, 1'b1, 18'h2D2D2, 2, 101); // R2
      step(3'd2, 8'h41, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h0,     4, 102);
      step(3'd1, 8'h41, 2'b00, 18'h11111, 1'b0, 1'b1, 18'h11111, 2, 103); // R2 alternating
      step(3'd2, 8'h44, 2'b00, 18'h00000, 1'b0, 1'b0, 18'h0,     4, 104);
      step(3'd2, 8'h45, 2'b00, 18'h00A44, 1'b0, 1'b0, 18'h0,     4, 105);
      step(3'd2, 8'h46, 2'b00, 18'h00A45, 1'b0, 1'b0, 18'h0,     4, 106);
      step(3'd2, 8'h47, 2'b00, 18'h00A46, 1'b0, 1'b0, 18'h0,     4, 107);
      step(3'd1, 8'h45, 2'b11, 18'h00A47, 1'b0, 1'b1, 18'h00A45, 6, 108); // R6 beat 0
      step(3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00A44, 6, 109); // R6 1^1
      step(3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00A47, 6, 110); // R6 1^2
      step(3'd3, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h00A46, 6, 111); // R6 1^3
      step(3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h0,     1, 112);
      step(3'd1, 8'h40, 2'b11, 18'h00000, 1'b1, 1'b0, 18'h0,     8, 113); // R8
      step(3'd1, 8'h40, 2'b11, 18'h00000, 1'b0, 1'b1, 18'h2D2D2, 2, 114);
      step(3'd0, 8'h00, 2'b11, 18'h00000, 1'b0, 1'b0, 18'h0,     1, 115);

      finish_run();
   end

endmodule